// File: doc/BRIEF.md
# Automatic Chip Erase Sequencer

This block runs a complete erase of a small modelled memory array with no help from the host once a start pulse arrives. It does not rely on the host having pre-programmed the array. It first forces every word to zero and confirms that each one reads back as zero. Only then does it apply erase pulses of fixed length. After each pulse it sweeps the array. The first word that is not yet all ones sends it back for another pulse. Once a sweep finds every word all ones, the block goes back to normal read mode by itself, and the host issues no separate verify step. The array model is a register file with a configurable number of pulses needed for erase margin. It stands in for real cells.

The host reaches the block through a plain request/response read port and a plain write port. Neither port applies back-pressure. A read request is answered on the next cycle. In read mode the answer is the addressed word. While the engine is working, or while it holds a failure, the answer is a status byte. In that byte, bit 7 is a completion bit, bit 6 flips on every status read, bit 5 reports an expired time limit and bit 3 shows that the erase pulses have begun. A cycle counter sets the time limit. When the limit is hit, the block stays in failure until the host sends an abort pulse. `DATA_W` must be at least 8.

Top module: `chip_erase_engine`

## Requirements
- R1: After reset the block is in read mode, the array holds all ones (every word reads 0xFF), and a read answers with `rd_valid` high one cycle after `rd_en`.
- R2: In read mode, `wr_en` stores `wr_data` at `wr_addr`. A read of that address one cycle later returns the stored value.
- R3: A start pulse accepted in read mode begins a pre-program phase that lasts 2·DEPTH cycles. In the first DEPTH cycles the engine writes zero to each word. In the next DEPTH cycles it checks that each word reads zero. Status bit 3 reads 0 during this phase and reads 1 from the first erase cycle onward.
- R4: Each erase pulse lasts ERASE_LAT cycles. It is followed by a sweep that checks one word per cycle, starting at address 0. A word that is not all ones starts a new pulse. The array reaches all ones after ERASE_PULSES pulses, so a successful operation lasts 3·DEPTH + ERASE_PULSES·ERASE_LAT + ERASE_PULSES − 1 cycles (74 with the defaults).
- R5: While the operation runs, or while a failure is held, status bit 7 reads 0.
- R6: Status bit 6 reads 0 on the first status read after a start. It inverts on each later status read.
- R7: When the operation succeeds, the block returns to read mode by itself. Every word then reads 0xFF, so bit 7 of read data is 1.
- R8: If an operation is still running after TIMEOUT cycles, the block enters failure. Status then reads bit 5 = 1, bit 7 = 0 and bit 3 = 1 if the erase had begun. This state holds for as long as no abort arrives.
- R9: An `abort` pulse clears a held failure and returns the block to read mode, leaving the array contents as they are. An abort in read mode or during a running operation has no effect.
- R10: While the block is running or holding a failure, `start` and `wr_en` are ignored. The array and the operation's timing are unchanged.
- R11: When `start` and `wr_en` are both high in read mode, the start is taken and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a chip erase |
| abort | input | 1 | One-cycle pulse that clears a held failure |
| wr_en | input | 1 | Host write strobe, honoured only in read mode |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | DATA_W | Host write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address (ignored when status is returned) |
| rd_valid | output | 1 | High one cycle after `rd_en` |
| rd_data | output | DATA_W | Array word in read mode, status byte otherwise |

## Verification
A behavioural reference model predicts the response to every read. The main function is tried on an array that holds a mix of 0x00, 0x55, 0xAA and erased words, and on an array that was just erased, so the final all-ones result cannot come from the starting contents. Polling in every cycle from the start pulse gives an exact busy length, which tells apart a missing pre-program phase, a wrong pulse count and a sweep that does not restart. It also shows where bit 3 switches between the pre-program and erase phases. A second instance with a short limit is driven into timeout, and the test checks that the failure holds, that start and write are blocked, and that abort leaves the zeroed array readable.

// File: rtl/ce_pkg.sv
package ce_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREPROG,
    ST_PREVER,
    ST_PULSE,
    ST_ERVER,
    ST_FAIL
  } ce_state_e;

  localparam int BIT_DONE    = 7;
  localparam int BIT_TOGGLE  = 6;
  localparam int BIT_TIMEOUT = 5;
  localparam int BIT_ERASING = 3;
endpackage

// File: rtl/ce_cell_array.sv
module ce_cell_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int PULSES = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              host_we,
  input  logic [ADDR_W-1:0]                 host_addr,
  input  logic [DATA_W-1:0]                 host_wdata,
  input  logic                              zero_we,
  input  logic [ADDR_W-1:0]                 zero_addr,
  input  logic                              margin_clr,
  input  logic                              pulse,
  input  logic [ADDR_W-1:0]                 host_raddr,
  output logic [DATA_W-1:0]                 host_rdata,
  input  logic [ADDR_W-1:0]                 ver_addr,
  output logic [DATA_W-1:0]                 ver_rdata,
  output logic                              all_erased,
  output logic [(1<<ADDR_W)*DATA_W-1:0]     cells
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int MW    = $clog2(PULSES + 1);

  logic [MW-1:0]     margin;
  logic              last_pulse;
  logic [DEPTH-1:0]  word_ones;
  logic [DATA_W-1:0] words [DEPTH];

  assign last_pulse = pulse && (margin == MW'(PULSES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                                  margin <= '0;
    else if (margin_clr)                         margin <= '0;
    else if (pulse && (margin != MW'(PULSES)))   margin <= margin + 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [DATA_W-1:0] word;
    always_ff @(posedge clk) begin
      if (!rst_n)                                          word <= '1;
      else if (last_pulse)                                 word <= '1;
      else if (zero_we && (zero_addr == ADDR_W'(g)))       word <= '0;
      else if (host_we && (host_addr == ADDR_W'(g)))       word <= host_wdata;
    end
    assign word_ones[g]                  = &word;
    assign words[g]                      = word;
    assign cells[g*DATA_W +: DATA_W]     = word;
  end

  assign host_rdata = words[host_raddr];
  assign ver_rdata  = words[ver_addr];
  assign all_erased = &word_ones;

  // R4: the pulse that reaches full margin leaves every word erased
  assert_margin_erases_R4: assert property (@(posedge clk) disable iff (!rst_n)
    last_pulse |=> all_erased);
endmodule

// File: rtl/ce_timeout.sv
module ce_timeout #(
  parameter int LIMIT = 1000,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          run,
  output logic          expired,
  output logic [CW-1:0] count
);
  assign expired = run && (count == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)               count <= '0;
    else if (clear)           count <= '0;
    else if (run && !expired) count <= count + 1'b1;
  end

  // R8: a running operation never sees the counter beyond its limit
  assert_count_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (count < CW'(LIMIT)));
endmodule

// File: rtl/ce_sequencer.sv
module ce_sequencer
  import ce_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int ERASE_LAT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              expired,
  input  logic [DATA_W-1:0] ver_rdata,
  output ce_state_e         state,
  output logic              accept,
  output logic              engaged,
  output logic              failed,
  output logic              erase_seen,
  output logic              zero_we,
  output logic              pulse,
  output logic [ADDR_W-1:0] addr
);
  localparam int LW = (ERASE_LAT > 1) ? $clog2(ERASE_LAT) : 1;
  localparam logic [ADDR_W-1:0] LAST = '1;

  ce_state_e         nstate;
  logic [ADDR_W-1:0] naddr;
  logic [LW-1:0]     lat_cnt, nlat;
  logic              nseen, finish;

  always_comb begin
    nstate  = state;
    naddr   = addr;
    nlat    = lat_cnt;
    nseen   = erase_seen;
    zero_we = 1'b0;
    pulse   = 1'b0;
    finish  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          nstate = ST_PREPROG;
          naddr  = '0;
          nseen  = 1'b0;
        end
      end
      ST_PREPROG: begin
        zero_we = 1'b1;
        if (addr == LAST) begin
          nstate = ST_PREVER;
          naddr  = '0;
        end else begin
          naddr = addr + 1'b1;
        end
      end
      ST_PREVER: begin
        if (ver_rdata != '0) begin
          nstate = ST_FAIL;
        end else if (addr == LAST) begin
          nstate = ST_PULSE;
          nlat   = '0;
          nseen  = 1'b1;
        end else begin
          naddr = addr + 1'b1;
        end
      end
      ST_PULSE: begin
        if (lat_cnt == LW'(ERASE_LAT - 1)) begin
          pulse  = 1'b1;
          nstate = ST_ERVER;
          naddr  = '0;
        end else begin
          nlat = lat_cnt + 1'b1;
        end
      end
      ST_ERVER: begin
        if (ver_rdata != '1) begin
          nstate = ST_PULSE;
          nlat   = '0;
        end else if (addr == LAST) begin
          nstate = ST_IDLE;
          finish = 1'b1;
        end else begin
          naddr = addr + 1'b1;
        end
      end
      ST_FAIL: begin
        if (abort) nstate = ST_IDLE;
      end
      default: nstate = ST_IDLE;
    endcase
    if (expired && !finish) nstate = ST_FAIL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      addr       <= '0;
      lat_cnt    <= '0;
      erase_seen <= 1'b0;
    end else begin
      state      <= nstate;
      addr       <= naddr;
      lat_cnt    <= nlat;
      erase_seen <= nseen;
    end
  end

  assign accept  = (state == ST_IDLE) && start;
  assign failed  = (state == ST_FAIL);
  assign engaged = (state == ST_PREPROG) || (state == ST_PREVER) ||
                   (state == ST_PULSE)   || (state == ST_ERVER);

  // R8: a held failure survives every cycle without an abort
  assert_fail_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (failed && !abort) |=> failed);

  // R9: an abort while running does not end the operation early
  assert_abort_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (engaged && abort && !expired && !finish) |=> (engaged || failed));
endmodule

// File: rtl/ce_status.sv
module ce_status
  import ce_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              accept,
  input  logic              engaged,
  input  logic              failed,
  input  logic              erase_seen,
  input  logic [DATA_W-1:0] host_rdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic              toggle;
  logic              busyish;
  logic [DATA_W-1:0] stat_word;

  assign busyish = engaged || failed;

  always_comb begin
    stat_word              = '0;
    stat_word[BIT_DONE]    = 1'b0;
    stat_word[BIT_TOGGLE]  = toggle;
    stat_word[BIT_TIMEOUT] = failed;
    stat_word[BIT_ERASING] = erase_seen;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                toggle <= 1'b0;
    else if (accept)           toggle <= 1'b0;
    else if (rd_en && busyish) toggle <= ~toggle;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= busyish ? stat_word : host_rdata;
    end
  end

  // R5: a status answer never claims completion
  assert_busy_not_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busyish) |=> !rd_data[BIT_DONE]);

  // R6: back-to-back status answers differ in the toggle bit
  assert_toggle_flips_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busyish) ##1 (rd_en && busyish) |=> (rd_data[BIT_TOGGLE] != $past(rd_data[BIT_TOGGLE])));

  // R8: a status answer during a held failure reports the timeout
  assert_fail_reported_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && failed) |=> rd_data[BIT_TIMEOUT]);
endmodule

// File: rtl/chip_erase_engine.sv
module chip_erase_engine
  import ce_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 8,
  parameter int ERASE_LAT    = 8,
  parameter int ERASE_PULSES = 3,
  parameter int TIMEOUT      = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = $clog2(TIMEOUT + 1);

  ce_state_e               st;
  logic                    accept, engaged, failed, erase_seen;
  logic                    zero_we, pulse, expired, host_we, all_erased;
  logic [ADDR_W-1:0]       seq_addr;
  logic [DATA_W-1:0]       host_rdata, ver_rdata;
  logic [DEPTH*DATA_W-1:0] cells;
  logic [CW-1:0]           tmr_count;

  assign host_we = wr_en && (st == ST_IDLE) && !start;

  ce_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSES(ERASE_PULSES)) u_array (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_addr(wr_addr), .host_wdata(wr_data),
    .zero_we(zero_we), .zero_addr(seq_addr),
    .margin_clr(accept), .pulse(pulse),
    .host_raddr(rd_addr), .host_rdata(host_rdata),
    .ver_addr(seq_addr), .ver_rdata(ver_rdata),
    .all_erased(all_erased), .cells(cells)
  );

  ce_timeout #(.LIMIT(TIMEOUT)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(accept), .run(engaged),
    .expired(expired), .count(tmr_count)
  );

  ce_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERASE_LAT(ERASE_LAT)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .expired(expired),
    .ver_rdata(ver_rdata), .state(st), .accept(accept), .engaged(engaged),
    .failed(failed), .erase_seen(erase_seen), .zero_we(zero_we), .pulse(pulse),
    .addr(seq_addr)
  );

  ce_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .accept(accept), .engaged(engaged),
    .failed(failed), .erase_seen(erase_seen), .host_rdata(host_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // R3: erase pulses begin only after the array has been seen all zero
  assert_zero_before_erase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_PULSE) && ($past(st) == ST_PREVER)) |-> $past(cells == '0));

  // R7: a successful finish leaves the whole array erased
  assert_finish_erased_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(engaged) && !failed) |-> all_erased);

  // R10: host writes cannot reach the array while running
  assert_cells_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (engaged && !zero_we && !pulse) |=> $stable(cells));

  // R10: nor while a failure is held
  assert_fail_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    failed |=> $stable(cells));

  // R8: the timer only counts while the sequencer is working
  assert_timer_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!engaged && !accept) |=> $stable(tmr_count));
endmodule

// File: tb/tb_chip_erase_engine.sv
module tb_chip_erase_engine;
  localparam int AW = 4, DW = 8, N = 16, LAT = 8, NP = 3, TOUT = 1000, TOUT_S = 40;
  localparam int T_OP = 3*N + NP*LAT + NP - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, start, abort, wr_en, rd_en, rd_valid;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data, rd_data;
  logic          t_start, t_abort, t_wr_en, t_rd_en, t_rd_valid;
  logic [AW-1:0] t_wr_addr, t_rd_addr;
  logic [DW-1:0] t_wr_data, t_rd_data;

  chip_erase_engine #(.ADDR_W(AW), .DATA_W(DW), .ERASE_LAT(LAT), .ERASE_PULSES(NP), .TIMEOUT(TOUT)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data));

  chip_erase_engine #(.ADDR_W(AW), .DATA_W(DW), .ERASE_LAT(LAT), .ERASE_PULSES(NP), .TIMEOUT(TOUT_S)) dut_to (
    .clk(clk), .rst_n(rst_n), .start(t_start), .abort(t_abort), .wr_en(t_wr_en), .wr_addr(t_wr_addr),
    .wr_data(t_wr_data), .rd_en(t_rd_en), .rd_addr(t_rd_addr), .rd_valid(t_rd_valid), .rd_data(t_rd_data));

  int    n_chk = 0, n_bad = 0;
  string req = "R1";
  bit    ended = 0;

  task automatic chk(string r, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", r, act, exp);
    end
  endtask

  task automatic report();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // behavioural reference model of the main instance
  logic [DW-1:0] m_mem [N];
  bit            m_busy, m_fail, m_tog, m_ev;
  int            m_k;
  logic [DW-1:0] m_ed;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_fail = 0; m_tog = 0; m_ev = 0; m_k = 0; m_ed = '0;
      for (int i = 0; i < N; i++) m_mem[i] = 8'hFF;
    end else begin
      m_ev = rd_en;
      if (rd_en) begin
        if (m_busy || m_fail) begin
          m_ed = {1'b0, m_tog, m_fail, 1'b0, (m_k >= 2*N), 3'b000};
          m_tog = ~m_tog;
        end else begin
          m_ed = m_mem[rd_addr];
        end
      end
      if (m_fail) begin
        if (abort) m_fail = 0;
      end else if (m_busy) begin
        m_k++;
        if (m_k == T_OP) begin
          m_busy = 0;
          for (int i = 0; i < N; i++) m_mem[i] = 8'hFF;
        end else if (m_k == TOUT) begin
          m_busy = 0; m_fail = 1;
        end
      end else if (start) begin
        m_busy = 1; m_k = 0; m_tog = 0;
      end else if (wr_en) begin
        m_mem[wr_addr] = wr_data;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      chk({req, " valid"}, {7'b0, rd_valid}, {7'b0, m_ev});
      if (m_ev) chk({req, " data"}, rd_data, m_ed);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    report();
  end

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
    d = rd_data;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic trd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    t_rd_en = 1; t_rd_addr = a;
    @(negedge clk);
    t_rd_en = 0;
    d = t_rd_data;
  endtask

  initial begin
    logic [DW-1:0] d, d2;
    int cnt;
    bit fin;
    rst_n = 0; start = 0; abort = 0; wr_en = 0; rd_en = 0;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    t_start = 0; t_abort = 0; t_wr_en = 0; t_rd_en = 0;
    t_wr_addr = '0; t_rd_addr = '0; t_wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset contents and read latency
    req = "R1";
    rd(4'd0, d);
    chk("R1", d, 8'hFF);
    chk("R1", {7'b0, rd_valid}, 8'h01);

    // R2: host writes in read mode
    req = "R2";
    wr(4'd3, 8'hAA); wr(4'd5, 8'h00); wr(4'd15, 8'h55); wr(4'd9, 8'h0F);
    rd(4'd3, d);  chk("R2", d, 8'hAA);
    rd(4'd5, d);  chk("R2", d, 8'h00);
    rd(4'd15, d); chk("R2", d, 8'h55);

    // R3 R4 R5 R6 R9 R10: full erase polled every cycle, with ignored stimuli at poll 10
    req = "R4";
    start = 1;
    @(negedge clk);
    start = 0;
    rd_en = 1; rd_addr = 4'd3;
    cnt = 0; fin = 0;
    while (!fin && cnt < 300) begin
      @(negedge clk);
      start = 0; wr_en = 0; abort = 0;
      if (rd_data[7]) fin = 1;
      else begin
        cnt++;
        chk("R3", {7'b0, rd_data[3]}, {7'b0, (cnt >= 2*N + 1)});
        chk("R6", {7'b0, rd_data[6]}, {7'b0, ~cnt[0]});
        if (cnt == 10) begin
          start = 1; abort = 1; wr_en = 1; wr_addr = 4'd3; wr_data = 8'h12;
        end
      end
    end
    rd_en = 0;
    chk("R4", 8'(cnt), 8'(T_OP));
    chk("R7", rd_data, 8'hFF);
    req = "R7";
    for (int i = 0; i < N; i++) begin
      rd(4'(i), d);
      chk("R7", d, 8'hFF);
    end
    rd(4'd3, d);
    chk("R10", d, 8'hFF);

    // R11: start beats a same-cycle write
    req = "R11";
    start = 1; wr_en = 1; wr_addr = 4'd7; wr_data = 8'h00;
    @(negedge clk);
    start = 0; wr_en = 0;
    rd(4'd7, d);
    chk("R11", {7'b0, d[7]}, 8'h00);
    repeat (T_OP + 4) @(negedge clk);
    rd(4'd7, d);
    chk("R11", d, 8'hFF);

    // R9: abort in read mode changes nothing
    req = "R9";
    wr(4'd2, 8'h3C);
    abort = 1;
    @(negedge clk);
    abort = 0;
    rd(4'd2, d);
    chk("R9", d, 8'h3C);

    // R8: timeout instance
    wr(4'd0, 8'h00);
    t_start = 1;
    @(negedge clk);
    t_start = 0;
    repeat (TOUT_S + 20) @(negedge clk);
    trd(4'd0, d);
    chk("R8", d & 8'hBF, 8'h28);
    repeat (100) @(negedge clk);
    trd(4'd0, d2);
    chk("R8", d2 & 8'hBF, 8'h28);
    chk("R6", {7'b0, d2[6]}, {7'b0, ~d[6]});
    // R10: start and write are blocked during a held failure
    t_start = 1; t_wr_en = 1; t_wr_addr = 4'd1; t_wr_data = 8'hC3;
    @(negedge clk);
    t_start = 0; t_wr_en = 0;
    trd(4'd1, d);
    chk("R10", d & 8'hBF, 8'h28);
    // R9: abort releases the failure, zeroed array visible
    t_abort = 1;
    @(negedge clk);
    t_abort = 0;
    trd(4'd1, d);
    chk("R9", d, 8'h00);
    trd(4'd9, d);
    chk("R9", d, 8'h00);

    repeat (3) @(negedge clk);
    report();
  end
endmodule